// File: doc/BRIEF.md
# Dual I/O Window Address Translator

This block sits between a host I/O decode path and a card slot. It holds two programmable I/O windows. For every host I/O request it decides whether the address falls inside one of them. On a hit it produces the card-side I/O address, the data width to use on the card (8 or 16 bits) and which of two timing register sets the cycle generator should apply. Cycle timing and the host bus protocol are handled elsewhere. This block only resolves the request.

Each window has a 16-bit inclusive start and end address at byte granularity and a 16-bit translation offset. It also has a control word with an enable bit, an automatic-width bit, a manual 16-bit select and a timing-set select. A simple synchronous register port writes these fields and reads them back. A request is presented with `req_valid` for one cycle, and its resolution appears on the registered result outputs on the next clock edge.

Top module: `iowin_dec`

## Requirements
- R1: After reset every register reads as zero, all windows are disabled, and all result outputs are zero.
- R2: A write on the register port takes effect from the next clock cycle. The register index is `cfg_addr[2]` = window and `cfg_addr[1:0]` = field (0 start, 1 end, 2 offset, 3 control). Control bits are: bit 0 enable, bit 1 automatic width, bit 2 manual 16-bit, bit 3 timing set. The control register stores only bits 3:0 and reads back zero-extended. `cfg_rdata` shows the addressed register combinationally. A lookup in the same cycle as a write uses the previous contents.
- R3: A window whose enable bit is 0 never matches.
- R4: An enabled window matches when start ≤ address ≤ end, with both bounds inclusive, at single-byte resolution over the full 0 to 0xFFFF range.
- R5: A window whose start is greater than its end never matches.
- R6: When both windows match, window 0 is reported.
- R7: On a hit, `res_card_addr` is the host address plus the hit window's offset, modulo 2^16.
- R8: On a hit, `res_wide` equals `card_is16` when the window's automatic-width bit is set. Otherwise it equals the manual 16-bit bit.
- R9: On a hit, `res_tset` equals the hit window's timing-set bit.
- R10: Results are registered. `res_valid` equals the previous cycle's `req_valid`. When the result is not a valid hit, `res_hit`, `res_win`, `res_card_addr`, `res_wide` and `res_tset` are all zero.
- R11: `res_write` equals the request's direction for a valid request and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index {window, field} |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for `cfg_addr` |
| req_valid | input | 1 | Host I/O request present |
| req_addr | input | 16 | Host I/O address |
| req_write | input | 1 | Request direction, 1 = write |
| card_is16 | input | 1 | Card reports a 16-bit port at this address |
| res_valid | output | 1 | Result of last cycle's request |
| res_hit | output | 1 | A window matched |
| res_win | output | 1 | Index of the matching window |
| res_card_addr | output | 16 | Translated card I/O address |
| res_wide | output | 1 | 1 = 16-bit access, 0 = 8-bit |
| res_tset | output | 1 | Selected timing register set |
| res_write | output | 1 | Direction of the resolved request |

## Verification
The hardest situations to reach from the ports are the ones where the answer depends on state that is changing or ambiguous. One is a lookup issued in the very cycle its window is being rewritten. The other is an address covered by both windows while one of them is disabled or reversed. The stimulus deliberately programs overlapping windows and then disables window 0 and reverses window 1. It closes with a phase of random register writes interleaved with random lookups in the same cycles, so that the stale-configuration rule and the priority rule are exercised together against a behavioural model.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

  // Field index inside one window's register group
  localparam int FLD_W = 2;
  localparam logic [FLD_W-1:0] FLD_START  = 2'd0;
  localparam logic [FLD_W-1:0] FLD_END    = 2'd1;
  localparam logic [FLD_W-1:0] FLD_OFFSET = 2'd2;
  localparam logic [FLD_W-1:0] FLD_CTRL   = 2'd3;

  // Control word, bit 0 upward: enable, automatic width, manual 16-bit, timing set
  typedef struct packed {
    logic tset;
    logic man16;
    logic autow;
    logic en;
  } iow_ctl_t;

  localparam int CTL_W = $bits(iow_ctl_t);

endpackage

// File: rtl/iowin_regs.sv
module iowin_regs
  import iowin_pkg::*;
#(
  parameter int NUM_WIN = 2,
  parameter int AW      = 16,
  localparam int WSEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int CFG_AW = WSEL_W + FLD_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [CFG_AW-1:0]            cfg_addr,
  input  logic [AW-1:0]                cfg_wdata,
  output logic [AW-1:0]                cfg_rdata,
  output logic [NUM_WIN-1:0][AW-1:0]   start_o,
  output logic [NUM_WIN-1:0][AW-1:0]   end_o,
  output logic [NUM_WIN-1:0][AW-1:0]   off_o,
  output iow_ctl_t [NUM_WIN-1:0]       ctl_o
);

  logic [WSEL_W-1:0] sel_win;
  logic [FLD_W-1:0]  sel_fld;

  assign sel_win = cfg_addr[CFG_AW-1:FLD_W];
  assign sel_fld = cfg_addr[FLD_W-1:0];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        start_o[w] <= '0;
        end_o[w]   <= '0;
        off_o[w]   <= '0;
        ctl_o[w]   <= '0;
      end else if (cfg_we && (int'(sel_win) == w)) begin
        case (sel_fld)
          FLD_START:  start_o[w] <= cfg_wdata;
          FLD_END:    end_o[w]   <= cfg_wdata;
          FLD_OFFSET: off_o[w]   <= cfg_wdata;
          default:    ctl_o[w]   <= iow_ctl_t'(cfg_wdata[CTL_W-1:0]);
        endcase
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (int'(sel_win) < NUM_WIN) begin
      case (sel_fld)
        FLD_START:  cfg_rdata = start_o[sel_win];
        FLD_END:    cfg_rdata = end_o[sel_win];
        FLD_OFFSET: cfg_rdata = off_o[sel_win];
        default:    cfg_rdata = {{(AW-CTL_W){1'b0}}, ctl_o[sel_win]};
      endcase
    end
  end

endmodule

// File: rtl/iowin_match.sv
module iowin_match
  import iowin_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic [AW-1:0] off,
  input  iow_ctl_t      ctl,
  input  logic          card_is16,
  output logic          hit,
  output logic [AW-1:0] xaddr,
  output logic          wide
);

  function automatic logic f_inside(input logic [AW-1:0] a,
                                    input logic [AW-1:0] s,
                                    input logic [AW-1:0] e);
    return (s <= a) && (a <= e);
  endfunction

  function automatic logic [AW-1:0] f_xlate(input logic [AW-1:0] a,
                                            input logic [AW-1:0] o);
    return a + o;
  endfunction

  function automatic logic f_width(input iow_ctl_t c, input logic is16);
    return c.autow ? is16 : c.man16;
  endfunction

  assign hit   = ctl.en && f_inside(addr, lo, hi);
  assign xaddr = f_xlate(addr, off);
  assign wide  = f_width(ctl, card_is16);

endmodule

// File: rtl/iowin_dec.sv
module iowin_dec
  import iowin_pkg::*;
#(
  parameter int NUM_WIN = 2,
  parameter int ADDR_W  = 16,
  localparam int WSEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int CFG_AW = WSEL_W + FLD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              card_is16,
  output logic              res_valid,
  output logic              res_hit,
  output logic [WSEL_W-1:0] res_win,
  output logic [ADDR_W-1:0] res_card_addr,
  output logic              res_wide,
  output logic              res_tset,
  output logic              res_write
);

  logic [NUM_WIN-1:0][ADDR_W-1:0] win_start;
  logic [NUM_WIN-1:0][ADDR_W-1:0] win_end;
  logic [NUM_WIN-1:0][ADDR_W-1:0] win_off;
  iow_ctl_t [NUM_WIN-1:0]         win_ctl;

  // Named per-window events for the checker
  logic [NUM_WIN-1:0]             match_vec;
  logic [NUM_WIN-1:0]             grant_vec;
  logic [NUM_WIN-1:0][ADDR_W-1:0] xaddr_vec;
  logic [NUM_WIN-1:0]             wide_vec;
  logic [WSEL_W-1:0]              sel_idx;
  logic                           any_match;
  logic                           take_hit;

  iowin_regs #(.NUM_WIN(NUM_WIN), .AW(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .start_o   (win_start),
    .end_o     (win_end),
    .off_o     (win_off),
    .ctl_o     (win_ctl)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
    iowin_match #(.AW(ADDR_W)) u_match (
      .addr      (req_addr),
      .lo        (win_start[w]),
      .hi        (win_end[w]),
      .off       (win_off[w]),
      .ctl       (win_ctl[w]),
      .card_is16 (card_is16),
      .hit       (match_vec[w]),
      .xaddr     (xaddr_vec[w]),
      .wide      (wide_vec[w])
    );
  end

  // Lowest-numbered matching window wins
  always_comb begin
    grant_vec = '0;
    sel_idx   = '0;
    any_match = 1'b0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (match_vec[i] && !any_match) begin
        grant_vec[i] = 1'b1;
        sel_idx      = i[WSEL_W-1:0];
        any_match    = 1'b1;
      end
    end
  end

  assign take_hit = req_valid && any_match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid     <= 1'b0;
      res_hit       <= 1'b0;
      res_win       <= '0;
      res_card_addr <= '0;
      res_wide      <= 1'b0;
      res_tset      <= 1'b0;
      res_write     <= 1'b0;
    end else begin
      res_valid     <= req_valid;
      res_hit       <= take_hit;
      res_win       <= take_hit ? sel_idx : '0;
      res_card_addr <= take_hit ? xaddr_vec[sel_idx] : '0;
      res_wide      <= take_hit && wide_vec[sel_idx];
      res_tset      <= take_hit && win_ctl[sel_idx].tset;
      res_write     <= req_valid && req_write;
    end
  end

endmodule

// File: rtl/iowin_chk.sv
module iowin_chk
  import iowin_pkg::*;
#(
  parameter int NUM_WIN = 2,
  parameter int AW      = 16,
  localparam int WSEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic                       res_valid,
  input logic                       res_hit,
  input logic [WSEL_W-1:0]          res_win,
  input logic [AW-1:0]              res_card_addr,
  input logic                       res_wide,
  input logic                       res_tset,
  input logic [NUM_WIN-1:0]         match_vec,
  input logic [NUM_WIN-1:0]         grant_vec,
  input logic [NUM_WIN-1:0][AW-1:0] win_start,
  input logic [NUM_WIN-1:0][AW-1:0] win_end,
  input iow_ctl_t [NUM_WIN-1:0]     win_ctl
);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !win_ctl[w].en |-> !match_vec[w]);
    assert_reversed_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (win_start[w] > win_end[w]) |-> !match_vec[w]);
  end

  assert_single_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  assert_win0_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    match_vec[0] |-> grant_vec[0]);

  assert_valid_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);

  assert_idle_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!res_valid && !res_hit));

  assert_miss_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !res_hit |-> (res_card_addr == '0 && !res_wide && !res_tset && res_win == '0));

  assert_hit_tracks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (res_hit == $past(|match_vec)));

endmodule

bind iowin_dec iowin_chk #(.NUM_WIN(NUM_WIN), .AW(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .res_valid     (res_valid),
  .res_hit       (res_hit),
  .res_win       (res_win),
  .res_card_addr (res_card_addr),
  .res_wide      (res_wide),
  .res_tset      (res_tset),
  .match_vec     (match_vec),
  .grant_vec     (grant_vec),
  .win_start     (win_start),
  .win_end       (win_end),
  .win_ctl       (win_ctl)
);

// File: tb/iowin_dec_bench.sv
module iowin_dec_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        card_is16 = 1'b0;
  logic        res_valid, res_hit, res_wide, res_tset, res_write;
  logic [0:0]  res_win;
  logic [15:0] res_card_addr;

  always #10 clk = ~clk;  // 50 MHz

  iowin_dec u_iowin_dec (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_write(req_write), .card_is16(card_is16),
    .res_valid(res_valid), .res_hit(res_hit), .res_win(res_win),
    .res_card_addr(res_card_addr), .res_wide(res_wide), .res_tset(res_tset),
    .res_write(res_write)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 0;
  string tag = "R1";
  int unsigned mreg [8];

  int e_valid, e_hit, e_win, e_ca, e_wide, e_tset, e_wr;

  task automatic check(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // One clock: inputs already driven after a falling edge
  task automatic cycle();
    #1;
    if (!cfg_we) check("cfg_rdata", int'(cfg_rdata), int'(mreg[cfg_addr]));
    e_valid = int'(req_valid);
    e_hit = 0; e_win = 0; e_ca = 0; e_wide = 0; e_tset = 0;
    e_wr = int'(req_valid && req_write);
    if (req_valid) begin
      for (int w = 0; w < 2; w++) begin
        int unsigned c, s, e, a;
        c = mreg[w*4+3]; s = mreg[w*4]; e = mreg[w*4+1]; a = req_addr;
        if (e_hit == 0 && (c & 1) != 0 && s <= a && a <= e) begin
          e_hit  = 1;
          e_win  = w;
          e_ca   = int'((a + mreg[w*4+2]) % 65536);
          e_wide = ((c & 2) != 0) ? int'(card_is16) : int'((c >> 2) & 1);
          e_tset = int'((c >> 3) & 1);
        end
      end
    end
    if (cfg_we) mreg[cfg_addr] = (cfg_addr[1:0] == 2'd3) ? (cfg_wdata & 16'hF) : cfg_wdata;
    @(posedge clk);
    @(negedge clk);
    check("res_valid", int'(res_valid), e_valid);
    check("res_hit", int'(res_hit), e_hit);
    check("res_win", int'(res_win), e_win);
    check("res_card_addr", int'(res_card_addr), e_ca);
    check("res_wide", int'(res_wide), e_wide);
    check("res_tset", int'(res_tset), e_tset);
    check("res_write", int'(res_write), e_wr);
  endtask

  task automatic wr(int a, int d);
    cfg_we = 1'b1; cfg_addr = a[2:0]; cfg_wdata = d[15:0];
    cycle();
    cfg_we = 1'b0;
  endtask

  task automatic rq(int a, bit w, bit is16);
    req_valid = 1'b1; req_addr = a[15:0]; req_write = w; card_is16 = is16;
    cycle();
    req_valid = 1'b0;
  endtask

  initial begin
    foreach (mreg[i]) mreg[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of all registers and results
    tag = "R1";
    for (int i = 0; i < 8; i++) begin cfg_addr = i[2:0]; cycle(); end
    rq(16'h0000, 0, 0);

    // R2: program and read back; control keeps bits 3:0 only
    tag = "R2";
    wr(0, 16'h0100); wr(1, 16'h01FF); wr(2, 16'h1000); wr(3, 16'hFFF1);
    wr(4, 16'h0180); wr(5, 16'h02FF); wr(6, 16'hF000); wr(7, 16'h000D);
    for (int i = 0; i < 8; i++) begin cfg_addr = i[2:0]; cycle(); end

    // R4: inclusive byte-granular bounds
    tag = "R4";
    rq(16'h00FF, 0, 0); rq(16'h0100, 0, 0); rq(16'h0200, 0, 0);
    rq(16'h02FF, 0, 0); rq(16'h0300, 0, 0);
    // R6: overlap region goes to window 0
    tag = "R6";
    rq(16'h0180, 0, 0); rq(16'h01FF, 1, 1);
    // R7: offset wrap modulo 2^16
    tag = "R7";
    wr(6, 16'hFF00);
    rq(16'h0200, 0, 0); rq(16'h02FF, 0, 0);
    // R8: automatic width follows card; manual used otherwise
    tag = "R8";
    wr(3, 16'h0003);
    rq(16'h0150, 0, 1); rq(16'h0150, 0, 0);
    wr(3, 16'h0005);
    rq(16'h0150, 0, 0);
    // R9: timing set follows the hit window
    tag = "R9";
    wr(3, 16'h0009);
    rq(16'h0120, 0, 0); rq(16'h0250, 0, 0);
    // R11: direction carried through
    tag = "R11";
    rq(16'h0120, 1, 0); rq(16'h0500, 1, 0);
    // R3: disabled window 0 lets window 1 answer the overlap
    tag = "R3";
    wr(3, 16'h000E);
    rq(16'h0180, 0, 0); rq(16'h0110, 0, 0);
    // R5: reversed bounds never match
    tag = "R5";
    wr(4, 16'h0400); wr(5, 16'h0300);
    rq(16'h0350, 0, 0); rq(16'h0400, 0, 0); rq(16'h0300, 0, 0);
    // R4: full range edges
    tag = "R4";
    wr(0, 16'h0000); wr(1, 16'hFFFF); wr(2, 16'h0001); wr(3, 16'h0001);
    rq(16'hFFFF, 0, 0); rq(16'h0000, 0, 0);
    // R10: idle cycle with a matching address produces nothing
    tag = "R10";
    req_addr = 16'h1234; cycle();
    // R2: lookup in the same cycle as a write uses the old value
    tag = "R2";
    req_valid = 1'b1; req_addr = 16'h0010; wr(3, 16'h0000); req_valid = 1'b0;
    rq(16'h0010, 0, 0);

    // Random mix of writes and lookups in the same cycles
    tag = "R6";
    for (int n = 0; n < 600; n++) begin
      int sel;
      sel = $urandom_range(7, 0);
      cfg_we    = ($urandom_range(3, 0) == 0);
      cfg_addr  = 3'(sel);
      cfg_wdata = (sel[1:0] == 2'd3) ? 16'($urandom_range(15, 0))
                : (sel[1:0] == 2'd2) ? 16'($urandom)
                : 16'($urandom_range(16'h0400, 0));
      req_valid = ($urandom_range(3, 0) != 0);
      req_addr  = 16'($urandom_range(16'h0420, 0));
      req_write = 1'($urandom);
      card_is16 = 1'($urandom);
      cycle();
    end
    cfg_we = 1'b0; req_valid = 1'b0;
    cycle();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule